// File: doc/BRIEF.md
# Privileged Control Register File

This block holds the internal control registers of a processor core behind one index-addressed access port. A single index selects a register. A read strobe returns its value in the same cycle. A write strobe commits the data word on the next clock edge. Each index carries its own rule, which sets whether it may be read, whether it may be written, which bits a write keeps, and whether a write has a side effect such as clearing the register or setting a one-shot flag. An access that breaks the rule raises a fault in the same cycle and leaves the register contents untouched.

Several registers need special handling. A group of eight scratch registers stores whole 64-bit words. A cycle-count register returns its stored upper half joined with a free-running counter in the lower half. A set of write-only command registers has no storage. Two of those commands, which invalidate translation buffer entries, appear as one-cycle output pulses, and the logic that owns the buffers acts on them.

Top module: `prf_regfile`

## Requirements
- R1: Indices 0 to 7 are scratch registers: a write stores all 64 bits and a read returns them unchanged.
- R2: A write to the exception return address register (index 10) stores the word with bit 1 forced to zero.
- R3: Writes to the trap request register (index 11) and the trap enable register (index 12) keep bits [3:0] only.
- R4: Writes to the current mode register (index 13) and the alternate mode register (index 14) keep bits 4 and 3 only (mask 0x18).
- R5: A write to the exception summary register (index 15) or the exception mask register (index 16) sets it to zero, whatever the write data.
- R6: A write to index 17 (interrupt identity), 18 (memory-management status) or 19 (page-entry temporary) raises the fault and leaves the register unchanged. Reads of these indices are legal.
- R7: A read of a command register (indices 22 to 27) raises the fault. Any access to an index from 28 to 63 raises the fault on either strobe.
- R8: A read of the cycle-count register (index 20) returns its stored bits [63:32] above bits [31:0] of a counter. The counter is zero in the first cycle after reset and advances by one each clock. A write to index 20 stores the full word.
- R9: The first write to the cycle-count control register (index 21) sets it to 1. Every later write raises the fault and changes nothing.
- R10: After reset every register reads zero, except index 8 (base address), which reads BASE_RESET, and index 9 (miscellaneous control), which reads 0x6.
- R11: The read data is zero whenever the fault output is high, and whenever no read strobe is given.
- R12: A write to index 26 raises `inv_all_o` and a write to index 27 raises `inv_proc_o`. Each pulse lasts for the cycle of the write strobe only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idx_i | input | 6 | Register index |
| wdata_i | input | 64 | Write data |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| rdata_o | output | 64 | Read data, valid in the cycle of the read strobe |
| fault_o | output | 1 | Illegal access in this cycle |
| inv_all_o | output | 1 | Pulse: invalidate all translation entries |
| inv_proc_o | output | 1 | Pulse: invalidate per-process translation entries |

## Verification
The assertions check on every cycle that:
- the stored mode and return-address registers never hold a bit outside their masks;
- a clear-on-write register is zero after each write to it;
- a rejected write to a read-only register leaves it stable;
- the one-shot control register only ever holds 0 or 1;
- the cycle counter steps by one each clock;
- a fault forces the read data to zero.

The bench's scenarios show the properties that depend on values, by comparing every cycle against a behavioural model:
- the mask and side effect of each index, including stimulus that reaches all 64 indices;
- the composed cycle-count read;
- the second-write rejection of the one-shot register;
- the reset contents.

// File: rtl/prf_pkg.sv
package prf_pkg;
    localparam int IDX_W  = 6;
    localparam int DATA_W = 64;
    localparam int SCR_N  = 8;
    localparam int NREG   = 28;
    localparam int REG_AW = $clog2(NREG);

    localparam int IX_BASE     = SCR_N;
    localparam int IX_MISC     = SCR_N + 1;
    localparam int IX_RET_ADDR = SCR_N + 2;
    localparam int IX_TRAP_REQ = SCR_N + 3;
    localparam int IX_TRAP_EN  = SCR_N + 4;
    localparam int IX_CUR_MODE = SCR_N + 5;
    localparam int IX_ALT_MODE = SCR_N + 6;
    localparam int IX_EXC_SUM  = SCR_N + 7;
    localparam int IX_EXC_MASK = SCR_N + 8;
    localparam int IX_INT_ID   = SCR_N + 9;
    localparam int IX_MM_STAT  = SCR_N + 10;
    localparam int IX_PTE_TMP  = SCR_N + 11;
    localparam int IX_CYC      = SCR_N + 12;
    localparam int IX_CYC_CTL  = SCR_N + 13;
    localparam int IX_CMD_LO   = SCR_N + 14;
    localparam int IX_INV_ALL  = SCR_N + 18;
    localparam int IX_INV_PROC = SCR_N + 19;

    typedef enum logic [1:0] {WR_NONE, WR_MASK, WR_CLEAR, WR_ONCE} wr_kind_e;

    typedef struct packed {
        logic              rd_ok;
        logic              wr_ok;
        logic              cyc_read;
        wr_kind_e          kind;
        logic [DATA_W-1:0] mask;
    } acc_rule_t;

    function automatic acc_rule_t rule_of(input logic [IDX_W-1:0] idx);
        acc_rule_t r;
        int        i;
        i          = int'(idx);
        r.rd_ok    = 1'b1;
        r.wr_ok    = 1'b1;
        r.cyc_read = 1'b0;
        r.kind     = WR_MASK;
        r.mask     = '1;
        if (i < SCR_N || i == IX_BASE || i == IX_MISC) begin
            r.mask = '1;
        end else if (i == IX_RET_ADDR) begin
            r.mask = ~64'h2;
        end else if (i == IX_TRAP_REQ || i == IX_TRAP_EN) begin
            r.mask = 64'hF;
        end else if (i == IX_CUR_MODE || i == IX_ALT_MODE) begin
            r.mask = 64'h18;
        end else if (i == IX_EXC_SUM || i == IX_EXC_MASK) begin
            r.kind = WR_CLEAR;
        end else if (i >= IX_INT_ID && i <= IX_PTE_TMP) begin
            r.wr_ok = 1'b0;
            r.kind  = WR_NONE;
        end else if (i == IX_CYC) begin
            r.cyc_read = 1'b1;
        end else if (i == IX_CYC_CTL) begin
            r.kind = WR_ONCE;
        end else if (i >= IX_CMD_LO && i < NREG) begin
            r.rd_ok = 1'b0;
            r.kind  = WR_NONE;
        end else begin
            r.rd_ok = 1'b0;
            r.wr_ok = 1'b0;
            r.kind  = WR_NONE;
        end
        return r;
    endfunction
endpackage

// File: rtl/prf_rule_dec.sv
module prf_rule_dec
    import prf_pkg::*;
(
    input  logic [IDX_W-1:0] idx_i,
    output acc_rule_t        rule_o
);
    always_comb rule_o = rule_of(idx_i);
endmodule

// File: rtl/prf_cycle_ctr.sv
module prf_cycle_ctr #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cnt_o
);
    always_ff @(posedge clk) begin
        if (rst) cnt_o <= '0;
        else     cnt_o <= cnt_o + 1'b1;
    end

    // R8: the live lower half advances by one on every clock
    a_r8_cnt_step: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> cnt_o == $past(cnt_o) + 1'b1);
endmodule

// File: rtl/prf_store.sv
module prf_store
    import prf_pkg::*;
#(
    parameter logic [DATA_W-1:0] BASE_RESET = 64'h0000_0000_0000_4000,
    parameter logic [DATA_W-1:0] MISC_RESET = 64'h6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  acc_rule_t         rule_i,
    output logic [DATA_W-1:0] regs_o [NREG]
);
    logic [REG_AW-1:0] slot;
    assign slot = idx_i[REG_AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NREG; k++) regs_o[k] <= '0;
            regs_o[IX_BASE] <= BASE_RESET;
            regs_o[IX_MISC] <= MISC_RESET;
        end else if (fire_i) begin
            unique case (rule_i.kind)
                WR_MASK:  regs_o[slot] <= wdata_i & rule_i.mask;
                WR_CLEAR: regs_o[slot] <= '0;
                WR_ONCE:  regs_o[slot] <= 64'd1;
                default:  ;
            endcase
        end
    end

    // R2: stored return address never carries bit 1
    a_r2_ret_bit1: assert property (@(posedge clk) disable iff (rst)
        regs_o[IX_RET_ADDR][1] == 1'b0);
    // R4: mode registers hold only bits 4:3
    a_r4_mode_bits: assert property (@(posedge clk) disable iff (rst)
        (regs_o[IX_CUR_MODE] & ~64'h18) == '0 && (regs_o[IX_ALT_MODE] & ~64'h18) == '0);
    // R5: clear-on-write registers are zero after a write to them
    a_r5_clears: assert property (@(posedge clk) disable iff (rst)
        fire_i && (int'(idx_i) == IX_EXC_SUM) |=> regs_o[IX_EXC_SUM] == '0);
    // R9: one-shot control holds only 0 or 1
    a_r9_once_value: assert property (@(posedge clk) disable iff (rst)
        regs_o[IX_CYC_CTL] <= 64'd1);
endmodule

// File: rtl/prf_regfile.sv
module prf_regfile
    import prf_pkg::*;
#(
    parameter logic [63:0] BASE_RESET = 64'h0000_0000_0000_4000,
    parameter logic [63:0] MISC_RESET = 64'h6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [5:0]  idx_i,
    input  logic [63:0] wdata_i,
    input  logic        rd_en_i,
    input  logic        wr_en_i,
    output logic [63:0] rdata_o,
    output logic        fault_o,
    output logic        inv_all_o,
    output logic        inv_proc_o
);
    localparam int HALF = DATA_W / 2;

    acc_rule_t         rule;
    logic [DATA_W-1:0] regs [NREG];
    logic [HALF-1:0]   cnt;
    logic              rd_bad, wr_bad, once_used, fire;
    logic [DATA_W-1:0] rd_val;

    prf_rule_dec u_dec (.idx_i(idx_i), .rule_o(rule));

    prf_cycle_ctr #(.CNT_W(HALF)) u_ctr (.clk(clk), .rst(rst), .cnt_o(cnt));

    prf_store #(.BASE_RESET(BASE_RESET), .MISC_RESET(MISC_RESET)) u_store (
        .clk(clk), .rst(rst), .fire_i(fire), .idx_i(idx_i),
        .wdata_i(wdata_i), .rule_i(rule), .regs_o(regs)
    );

    always_comb begin
        once_used = (rule.kind == WR_ONCE) && (regs[IX_CYC_CTL] != '0);
        rd_bad    = rd_en_i && !rule.rd_ok;
        wr_bad    = wr_en_i && (!rule.wr_ok || once_used);
        fault_o   = rd_bad || wr_bad;
        fire      = wr_en_i && !fault_o;
        if (rule.cyc_read) rd_val = {regs[IX_CYC][DATA_W-1:HALF], cnt};
        else if (rule.rd_ok) rd_val = regs[idx_i[REG_AW-1:0]];
        else rd_val = '0;
        rdata_o    = (rd_en_i && !fault_o) ? rd_val : '0;
        inv_all_o  = fire && (int'(idx_i) == IX_INV_ALL);
        inv_proc_o = fire && (int'(idx_i) == IX_INV_PROC);
    end

    // R11: a faulting access returns zero data
    a_r11_fault_zero: assert property (@(posedge clk) disable iff (rst)
        fault_o |-> rdata_o == '0);
    // R6: a rejected write leaves the interrupt identity register unchanged
    a_r6_ro_stable: assert property (@(posedge clk) disable iff (rst)
        wr_en_i && (int'(idx_i) == IX_INT_ID) |=> $stable(regs[IX_INT_ID]));
    // R12: invalidate pulses never overlap
    a_r12_pulse_excl: assert property (@(posedge clk) disable iff (rst)
        !(inv_all_o && inv_proc_o));
endmodule

// File: tb/test_prf_regfile.sv
`timescale 1ns/1ps
module test_prf_regfile;
    localparam logic [63:0] BASE_VAL = 64'h0000_0000_0000_4000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  idx = '0;
    logic [63:0] wdata = '0;
    logic        rd_en = 1'b0, wr_en = 1'b0;
    logic [63:0] rdata;
    logic        fault, inv_all, inv_proc;

    int checks = 0, fails = 0;
    logic [63:0] m [64];
    longint unsigned cyc = 0;

    always #10 clk = ~clk;

    prf_regfile i_prf_regfile (
        .clk(clk), .rst(rst), .idx_i(idx), .wdata_i(wdata),
        .rd_en_i(rd_en), .wr_en_i(wr_en), .rdata_o(rdata),
        .fault_o(fault), .inv_all_o(inv_all), .inv_proc_o(inv_proc)
    );

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    function automatic string req_of(int i);
        if (i < 8) return "R1";
        if (i == 8 || i == 9) return "R10";
        if (i == 10) return "R2";
        if (i == 11 || i == 12) return "R3";
        if (i == 13 || i == 14) return "R4";
        if (i == 15 || i == 16) return "R5";
        if (i >= 17 && i <= 19) return "R6";
        if (i == 20) return "R8";
        if (i == 21) return "R9";
        if (i == 26 || i == 27) return "R12";
        return "R7";
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic op(bit rd, bit wr, int i, logic [63:0] w);
        bit          ef;
        logic [63:0] er;
        @(negedge clk);
        idx = 6'(i); wdata = w; rd_en = rd; wr_en = wr;
        #1;
        ef = 0;
        if (rd && (i >= 22)) ef = 1;
        if (wr && ((i >= 17 && i <= 19) || i >= 28 || (i == 21 && m[21] != 0))) ef = 1;
        er = '0;
        if (rd && !ef) er = (i == 20) ? {m[20][63:32], cyc[31:0]} : m[i];
        check(req_of(i), {63'd0, fault}, {63'd0, ef});
        check(ef ? "R11" : req_of(i), rdata, er);
        check("R12", {62'd0, inv_all, inv_proc},
              {62'd0, wr && !ef && i == 26, wr && !ef && i == 27});
        @(posedge clk);
        if (wr && !ef) begin
            if (i < 10 || i == 20) m[i] = w;
            else if (i == 10) m[i] = w & ~64'h2;
            else if (i == 11 || i == 12) m[i] = w & 64'hF;
            else if (i == 13 || i == 14) m[i] = w & 64'h18;
            else if (i == 15 || i == 16) m[i] = '0;
            else if (i == 21) m[i] = 64'd1;
        end
    endtask

    initial begin
        #(200000 * 20);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected finish");
        report();
    end

    initial begin
        for (int k = 0; k < 64; k++) m[k] = '0;
        m[8] = BASE_VAL;
        m[9] = 64'h6;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R10 reset contents
        op(1, 0, 8, '0);
        op(1, 0, 9, '0);
        op(1, 0, 0, '0);
        op(1, 0, 15, '0);
        // R1 full-width scratch
        op(0, 1, 3, 64'hDEAD_BEEF_0123_4567);
        op(1, 0, 3, '0);
        // R2 return address bit 1
        op(0, 1, 10, '1);
        op(1, 0, 10, '0);
        // R3 trap registers
        op(0, 1, 11, 64'hFF);
        op(1, 0, 11, '0);
        // R4 mode bits
        op(0, 1, 14, '1);
        op(1, 0, 14, '0);
        // R5 clear on write
        op(0, 1, 16, '1);
        op(1, 0, 16, '0);
        // R6 read-only write faults
        op(0, 1, 17, '1);
        op(1, 0, 17, '0);
        // R7 illegal reads
        op(1, 0, 22, '0);
        op(1, 0, 40, '0);
        op(0, 1, 63, '1);
        // R8 composed cycle count
        op(0, 1, 20, 64'hAAAA_5555_FFFF_FFFF);
        op(1, 0, 20, '0);
        op(1, 0, 20, '0);
        // R9 one-shot
        op(0, 1, 21, 64'h77);
        op(1, 0, 21, '0);
        op(0, 1, 21, 64'h0);
        // R12 invalidate pulses
        op(0, 1, 26, '0);
        op(0, 1, 27, '0);
        op(0, 0, 26, '0);
        // R11 idle cycle returns zero
        op(0, 0, 3, '0);
        for (int n = 0; n < 600; n++) begin
            int sel = $urandom_range(0, 3);
            op(sel[0], sel[1], $urandom_range(0, 63), {$urandom, $urandom});
        end
        report();
    end
endmodule